// File: doc/BRIEF.md
# Interleaved Chroma Phase Tracker

This block follows the sample order of interleaved 4:2:2 video so that the logic after it can tell blue-difference (Cb) samples from red-difference (Cr) samples, and chroma from luma when a single port carries both. It runs on the master clock. From the reset it builds a half-rate enable whose phase is known. A falling edge on the sync control marks the first Cb sample of the stream. After that, every accepted sample goes out one cycle later with a valid strobe and a tag.

Two stream layouts are supported, chosen by a static mode input. In dual-chroma mode the chroma port carries Cb and Cr in alternate master cycles. In single-channel mode the luma port carries the repeating order Cb, Y, Cr, Y, so Cb returns every fourth master cycle. In that mode only a sync edge seen in a cycle where the half-rate enable is high counts.

The sync control may be pulsed once at start-up and then held low. It may also fall again on each Cb sample to resynchronise. A resynchronising edge that lands where no Cb was expected pulls the sequence back to Cb and raises a one-cycle phase-error pulse.

Top module: `chroma_phase_tracker`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs are 0 after that edge: `half_en`, `smp_valid`, `tag_cr`, `tag_luma`, `phase_err` and `smp_data`. Reset also clears the tracking, so no sample is valid until a new sync edge is accepted.
- R2: After reset is released, `half_en` is 1 after the first edge and then toggles on every master clock edge.
- R3: A sync edge is the case where `sync_in` was 1 at the previous edge and is 0 at the current edge. The first edge that is accepted makes `smp_valid` 1 after that same edge, with the sample tagged Cb (`tag_cr`=0, `tag_luma`=0).
- R4: In dual-chroma mode (`mode_422`=0), once a stream has started, `smp_valid` is 1 on every cycle. `tag_cr` alternates 0 (Cb) and 1 (Cr), `tag_luma` is 0, and `smp_data` is the value that was on `chroma_in` at the edge.
- R5: In single-channel mode (`mode_422`=1), `smp_data` comes from `luma_in`. The tags run Cb, Y, Cr, Y and then repeat: (`tag_cr`,`tag_luma`) = (0,0), (0,1), (1,0), (0,1).
- R6: In single-channel mode, a sync edge is accepted only if `half_en` was 1 just before the edge. Any other sync edge has no effect on the tags and raises no error.
- R7: An accepted sync edge that falls on a Cb position leaves the sequence unchanged and raises no error.
- R8: An accepted sync edge that falls on a non-Cb position after a stream has started forces that sample's tag to Cb, restarts the sequence from Cb, and sets `phase_err` for exactly one cycle.
- R9: Whenever `smp_valid` is 0, `tag_cr`, `tag_luma`, `phase_err` and `smp_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset; sets the half-rate phase |
| sync_in | input | 1 | Sync control; its falling edge marks a Cb sample |
| mode_422 | input | 1 | 0 = dual-chroma interleave on `chroma_in`; 1 = single-channel 4:2:2 on `luma_in` |
| chroma_in | input | 13 | Interleaved Cb/Cr sample bus |
| luma_in | input | 13 | Single-channel Cb/Y/Cr/Y sample bus |
| half_en | output | 1 | Half-rate enable aligned by reset |
| smp_valid | output | 1 | Registered sample is valid |
| smp_data | output | 13 | Registered sample from the bus selected by the mode |
| tag_cr | output | 1 | 0 = Cb, 1 = Cr (chroma samples only) |
| tag_luma | output | 1 | 1 = luma sample (single-channel mode only) |
| phase_err | output | 1 | One-cycle pulse: a resync edge arrived at a non-Cb position |

## Verification
The functions that can meet in one cycle are the resync edge and the running sequence step. An accepted sync edge that arrives where Cr or luma was due has to win over the normal step: the tag is forced to Cb and the error pulse fires in that same cycle. The bench sets this up by raising sync one cycle before a Cr position, in both modes. It then checks that the tag goes to Cb, that `phase_err` is high for that one cycle only, and that the next samples follow the restarted order. In single-channel mode, an edge placed in a cycle where `half_en` was low must leave the running sequence unchanged with no error; the same vector walk checks this.

// File: rtl/chroma_phase_pkg.sv
// Shared types for the chroma phase tracker.
// Assumes: one mode value per stream; the mode does not change while a stream runs.
package chroma_phase_pkg;
    typedef enum logic {
        MODE_DUAL_CHROMA = 1'b0,
        MODE_SINGLE_422  = 1'b1
    } stream_mode_t;

    typedef struct packed {
        logic cr;
        logic luma;
    } sample_tag_t;

    localparam int unsigned DEF_SAMPLE_W = 13;
    localparam int unsigned DEF_GROUP_LEN = 4;
endpackage

// File: rtl/half_rate_gen.sv
// Half-rate enable generator.
// Reset holds the phase at 0. After release the enable is high after the
// first edge and toggles on every edge after that, so the half-rate rising
// edge sits on a known master edge.
module half_rate_gen (
    input  logic clk,
    input  logic rst_n,
    output logic half_en
);
    logic phase_q;

    // Toggle register: cleared by reset, inverted on every master edge.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= ~phase_q;
    end

    assign half_en = phase_q;
endmodule

// File: rtl/sync_fall_qual.sv
// Sync edge qualifier.
// Latches sync on each master edge. A falling edge is sync high at the
// previous edge and low now. In single-channel mode the edge counts only
// when the half-rate enable is high in the cycle before the edge.
// Assumes: sync_in is already in the master clock domain.
module sync_fall_qual
    import chroma_phase_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sync_in,
    input  logic         half_en,
    input  stream_mode_t mode,
    output logic         fall_ok
);
    logic sync_prev;
    logic fall_raw;
    logic phase_gate;

    // Keep the level of sync from the previous edge; cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_prev <= 1'b0;
        else        sync_prev <= sync_in;
    end

    // Falling edge, and the phase gate that single-channel mode needs.
    always_comb begin
        fall_raw   = sync_prev & ~sync_in;
        phase_gate = (mode == MODE_DUAL_CHROMA) | half_en;
        fall_ok    = fall_raw & phase_gate;
    end
endmodule

// File: rtl/phase_sequencer.sv
// Sample phase sequencer.
// Counts the position of each sample in its group (2 in dual-chroma mode,
// GROUP_LEN in single-channel mode). A qualified sync edge restarts the
// count at the Cb position. It registers the selected sample and its tag,
// and flags a sync edge that arrives at a non-Cb position once a stream
// has started.
// Assumes: GROUP_LEN is a power of two and at least 4; Cr sits half a group after Cb.
module phase_sequencer
    import chroma_phase_pkg::*;
#(
    parameter int unsigned SAMPLE_W  = DEF_SAMPLE_W,
    parameter int unsigned GROUP_LEN = DEF_GROUP_LEN
) (
    input  logic                clk,
    input  logic                rst_n,
    input  stream_mode_t        mode,
    input  logic                fall_ok,
    input  logic [SAMPLE_W-1:0] chroma_in,
    input  logic [SAMPLE_W-1:0] luma_in,
    output logic                smp_valid,
    output logic [SAMPLE_W-1:0] smp_data,
    output sample_tag_t         smp_tag,
    output logic                phase_err
);
    localparam int unsigned POS_W = $clog2(GROUP_LEN);
    localparam logic [POS_W-1:0] POS_CB      = '0;
    localparam logic [POS_W-1:0] POS_LAST_1  = POS_W'(GROUP_LEN - 1);
    localparam logic [POS_W-1:0] POS_CR_1    = POS_W'(GROUP_LEN / 2);
    localparam logic [POS_W-1:0] POS_LAST_2  = POS_W'(1);

    logic              started;
    logic [POS_W-1:0]  pos_q;
    logic [POS_W-1:0]  cur_pos;
    logic [POS_W-1:0]  nxt_pos;
    logic [POS_W-1:0]  last_pos;
    sample_tag_t       cur_tag;
    logic [SAMPLE_W-1:0] bus_sel;
    logic              emit;

    // Position of the current sample: a sync edge restarts at Cb.
    always_comb begin
        cur_pos  = fall_ok ? POS_CB : pos_q;
        last_pos = (mode == MODE_SINGLE_422) ? POS_LAST_1 : POS_LAST_2;
        nxt_pos  = (cur_pos == last_pos) ? POS_CB : cur_pos + POS_W'(1);
        emit     = fall_ok | started;
    end

    // Tag decode of the current position for the active mode.
    always_comb begin
        if (mode == MODE_SINGLE_422) begin
            cur_tag.cr   = (cur_pos == POS_CR_1);
            cur_tag.luma = cur_pos[0];
        end else begin
            cur_tag.cr   = cur_pos[0];
            cur_tag.luma = 1'b0;
        end
        bus_sel = (mode == MODE_SINGLE_422) ? luma_in : chroma_in;
    end

    // Tracking state: start flag and position, both cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started <= 1'b0;
            pos_q   <= POS_CB;
        end else if (emit) begin
            started <= 1'b1;
            pos_q   <= nxt_pos;
        end
    end

    // Output register: sample, tag, valid and the resync error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !emit) begin
            smp_valid <= 1'b0;
            smp_data  <= '0;
            smp_tag   <= '0;
            phase_err <= 1'b0;
        end else begin
            smp_valid <= 1'b1;
            smp_data  <= bus_sel;
            smp_tag   <= cur_tag;
            phase_err <= fall_ok & started & (pos_q != POS_CB);
        end
    end
endmodule

// File: rtl/chroma_phase_tracker.sv
// Interleaved chroma phase tracker (top).
// Joins the half-rate enable, the sync edge qualifier and the phase
// sequencer. Outputs are registered and appear one cycle after the edge
// that sampled the inputs.
// Assumes: mode_422 is static while a stream runs; rst_n is synchronous.
module chroma_phase_tracker
    import chroma_phase_pkg::*;
#(
    parameter int unsigned SAMPLE_W  = DEF_SAMPLE_W,
    parameter int unsigned GROUP_LEN = DEF_GROUP_LEN
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sync_in,
    input  logic                mode_422,
    input  logic [SAMPLE_W-1:0] chroma_in,
    input  logic [SAMPLE_W-1:0] luma_in,
    output logic                half_en,
    output logic                smp_valid,
    output logic [SAMPLE_W-1:0] smp_data,
    output logic                tag_cr,
    output logic                tag_luma,
    output logic                phase_err
);
    stream_mode_t mode;
    logic         fall_ok;
    sample_tag_t  tag;

    assign mode = stream_mode_t'(mode_422);

    half_rate_gen u_half (
        .clk     (clk),
        .rst_n   (rst_n),
        .half_en (half_en)
    );

    sync_fall_qual u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_in (sync_in),
        .half_en (half_en),
        .mode    (mode),
        .fall_ok (fall_ok)
    );

    phase_sequencer #(
        .SAMPLE_W  (SAMPLE_W),
        .GROUP_LEN (GROUP_LEN)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .fall_ok   (fall_ok),
        .chroma_in (chroma_in),
        .luma_in   (luma_in),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .smp_tag   (tag),
        .phase_err (phase_err)
    );

    assign tag_cr   = tag.cr;
    assign tag_luma = tag.luma;
endmodule

// File: rtl/chroma_phase_tracker_chk.sv
// Property checker for the chroma phase tracker, bound to the top module.
// Watches ports only.
module chroma_phase_tracker_chk (
    input logic clk,
    input logic rst_n,
    input logic mode_422,
    input logic half_en,
    input logic smp_valid,
    input logic tag_cr,
    input logic tag_luma,
    input logic phase_err
);
    // R1: one edge after reset, the enable and the strobe are low.
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) == 1'b0) |-> (!half_en && !smp_valid && !phase_err));

    // R2: after the first released cycle, the half-rate enable toggles.
    a_r2_half_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) == 1'b1) |=> (half_en != $past(half_en)));

    // R4: in dual-chroma mode, valid samples alternate Cb and Cr unless resynced.
    a_r4_dual_alternate: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_422 && smp_valid) |=>
            ((smp_valid && !phase_err && !mode_422) -> (tag_cr != $past(tag_cr))));

    // R5: a luma tag never comes with a Cr tag, and only in single-channel mode.
    a_r5_luma_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        tag_luma |-> (!tag_cr && smp_valid));

    // R8: the phase error lasts a single cycle.
    a_r8_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        phase_err |=> !phase_err);

    // R8: a phase error always goes with a valid Cb sample.
    a_r8_err_is_cb: assert property (@(posedge clk) disable iff (!rst_n)
        phase_err |-> (smp_valid && !tag_cr && !tag_luma));

    // R9: with no valid sample, tags and error are low.
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |-> (!tag_cr && !tag_luma && !phase_err));
endmodule

bind chroma_phase_tracker chroma_phase_tracker_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_422  (mode_422),
    .half_en   (half_en),
    .smp_valid (smp_valid),
    .tag_cr    (tag_cr),
    .tag_luma  (tag_luma),
    .phase_err (phase_err)
);

// File: tb/tb_chroma_phase_tracker.sv
// Bench for the chroma phase tracker: a vector walk and then directed tests.
module tb_chroma_phase_tracker;
    localparam int W = 13;
    localparam int NV = 27;
    localparam logic [W-1:0] CHR_BASE = 13'h100;
    localparam logic [W-1:0] LUM_BASE = 13'h200;

    // Vector bits: {rst_n, mode, sync, exp_half, exp_valid, exp_cr, exp_luma, exp_err}
    localparam logic [7:0] VEC [NV] = '{
        8'b101_10000, 8'b100_01000, 8'b100_11100, 8'b100_01000, 8'b101_11100,
        8'b100_01000, 8'b101_11100, 8'b101_01000, 8'b100_11001, 8'b100_01100,
        8'b011_00000, 8'b111_10000, 8'b110_01000, 8'b110_11010, 8'b110_01100,
        8'b111_11010, 8'b110_01000, 8'b111_11010, 8'b110_01001, 8'b111_11010,
        8'b111_01100, 8'b110_11010, 8'b110_01000, 8'b110_11010, 8'b110_01100,
        8'b010_00000, 8'b100_10000
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_in = 1'b0;
    logic mode_422 = 1'b0;
    logic [W-1:0] chroma_in = '0;
    logic [W-1:0] luma_in = '0;
    logic half_en, smp_valid, tag_cr, tag_luma, phase_err;
    logic [W-1:0] smp_data;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    chroma_phase_tracker dut (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .mode_422(mode_422),
        .chroma_in(chroma_in), .luma_in(luma_in), .half_en(half_en),
        .smp_valid(smp_valid), .smp_data(smp_data), .tag_cr(tag_cr),
        .tag_luma(tag_luma), .phase_err(phase_err)
    );

    // Requirement a vector mainly exercises.
    function automatic string vec_req(int i);
        if (i == 1)              return "R3";
        if (i == 5 || i == 16)   return "R7";
        if (i == 8 || i == 18)   return "R8";
        if (i == 21)             return "R6";
        if (i == 10 || i == 25)  return "R1";
        if (i == 11 || i == 26)  return "R9";
        if (i < 10)              return "R4";
        return "R5";
    endfunction

    task automatic check(string req, string what, logic [W+4:0] act, logic [W+4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        #1;
        tick(); tick(); tick();
        check("R1", "reset outputs", {half_en, smp_valid, tag_cr, tag_luma, phase_err, smp_data},
              '0);

        // Vector walk: dual-chroma, single-channel, resyncs and mid-stream reset.
        for (int i = 0; i < NV; i++) begin
            rst_n     = VEC[i][7];
            mode_422  = VEC[i][6];
            sync_in   = VEC[i][5];
            chroma_in = CHR_BASE + W'(i);
            luma_in   = LUM_BASE + W'(i);
            tick();
            check(vec_req(i), $sformatf("vec %0d flags", i),
                  {13'd0, half_en, smp_valid, tag_cr, tag_luma, phase_err},
                  {13'd0, VEC[i][4:0]});
            check(vec_req(i), $sformatf("vec %0d data", i), {5'd0, smp_data},
                  VEC[i][3] ? {5'd0, (VEC[i][6] ? LUM_BASE : CHR_BASE) + W'(i)} : '0);
        end

        // R2: the enable keeps toggling after release.
        for (int k = 0; k < 6; k++) begin
            logic prev;
            prev = half_en;
            tick();
            check("R2", "half_en toggle", {17'd0, half_en}, {17'd0, ~prev});
        end

        // R9: sync held low after reset, so no sample may appear.
        for (int k = 0; k < 4; k++) begin
            tick();
            check("R9", "idle before sync", {smp_valid, tag_cr, tag_luma, phase_err, 14'd0}, '0);
        end

        // R1: reset held while sync toggles, with a running stream.
        sync_in = 1'b1; tick(); sync_in = 1'b0; tick();
        check("R3", "dual start valid", {17'd0, smp_valid}, 18'd1);
        rst_n = 1'b0;
        for (int k = 0; k < 3; k++) begin
            sync_in = k[0];
            tick();
            check("R1", "held reset", {half_en, smp_valid, tag_cr, tag_luma, phase_err, smp_data}, '0);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule